// File: doc/BRIEF.md
# Page-Erase Flash Command Controller

This block fronts a 16-bit-wide nonvolatile array, modelled here as a register array, and runs three commands on it: fetching a halfword, programming a halfword, and erasing a whole page. A core sets up an address register and a data register, then writes a command code. Programming and erasing take a long, timed interval. For that whole interval the core is held off by a low ready signal. Reads, rejected commands and bad addresses finish at once.

Programming can only clear bits. Each halfword may be programmed at most twice between erasures, and a third attempt is refused without touching the stored value. The highest pages form a reserved region that user commands may read but not alter. The duration of a program operation follows a 3-bit clock-divider input. The duration of an erase is a fixed cycle count that does not depend on the divider.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the status register reads 0 and every halfword of the array reads 0xFFFF, with every per-location program count at zero.
- R2: The register map is selected by busSel: 0 command (write), 1 byte address, 2 data, 3 status (read-only). The halfword index is address bits [15:1].
- R3: Command 0x02 programs one halfword: the stored value becomes the old value ANDed with the data register. No other location changes.
- R4: A program keeps busReady low for P times CYC_PER_US cycles after the command-write edge, where P is 50 for divider 0 to 3, 70 for 4 and 5, 80 for 6 and 105 for 7.
- R5: Command 0x03 sets all PAGE_HW halfwords of the page holding the address to 0xFFFF and clears their program counts. Other pages are left as they were.
- R6: An erase keeps busReady low for exactly ERASE_CYC cycles, whatever the divider value.
- R7: A third program of a halfword with no erase in between is refused at once. busReady stays high, the status fail bit is set, and the data is unchanged.
- R8: Program or erase aimed at the reserved top RSV_PAGES pages, or at an index at or beyond the array size, fails at once with no stall and no array change. Command 0x01 may read the reserved region but fails beyond the array.
- R9: Any command code other than 0x01, 0x02 or 0x03 fails at once with no stall.
- R10: Status bit 0 is busy, bit 1 is complete and bit 2 is fail. Every finished or refused command sets complete, and a refused one also sets fail. A status read clears bits 1 and 2.
- R11: Command 0x01 copies the addressed halfword into the data register and sets complete without stalling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe |
| busSel | input | 2 | Register select |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data of the selected register |
| busReady | output | 1 | Low while a program or erase is in progress |
| clkDiv | input | 3 | Divider setting, sampled at command issue |

## Verification
The assertions assume that the core honours the stall. While busReady is low it issues no register write or read, so the address and data registers cannot move under a running operation. They also assume that busWr and busRd are never high in the same cycle. The stimulus keeps to both rules. Every task waits for ready before it drives the bus, and each task drives only one strobe, for a single cycle.

// File: rtl/fc_pkg.sv
package fc_pkg;

  localparam logic [1:0] SEL_CMD  = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;
  localparam logic [1:0] SEL_STAT = 2'd3;

  localparam logic [7:0] CMD_READ  = 8'h01;
  localparam logic [7:0] CMD_PROG  = 8'h02;
  localparam logic [7:0] CMD_ERASE = 8'h03;

  // strobes from control to datapath
  typedef struct packed {
    logic ldAddr;
    logic ldData;
    logic doRead;
    logic doProg;
    logic doErase;
  } fcStrb_t;

  // program duration in microseconds per divider setting
  function automatic int progMicros(input logic [2:0] div);
    case (div)
      3'd0, 3'd1, 3'd2, 3'd3: return 50;
      3'd4, 3'd5:             return 70;
      3'd6:                   return 80;
      default:                return 105;
    endcase
  endfunction

endpackage

// File: rtl/flash_cmd_dpath.sv
module flash_cmd_dpath
  import fc_pkg::*;
#(
  parameter int PAGE_HW   = 256,
  parameter int NUM_PAGES = 4,
  parameter int RSV_PAGES = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  fcStrb_t     strb,
  input  logic [15:0] wdata,
  output logic [15:0] addrQ,
  output logic [15:0] dataQ,
  output logic        addrBad,
  output logic        userBad,
  output logic        countFull
);

  localparam int TOTAL_HW = PAGE_HW * NUM_PAGES;
  localparam int USER_HW  = PAGE_HW * (NUM_PAGES - RSV_PAGES);
  localparam int IDX_W    = $clog2(TOTAL_HW);
  localparam int OFF_W    = $clog2(PAGE_HW);

  logic [15:0] memQ  [TOTAL_HW];
  logic [1:0]  wcntQ [TOTAL_HW];

  logic [14:0]      hwIdx;
  logic [IDX_W-1:0] idxS;
  logic [15:0]      curWord;
  logic [1:0]       curCnt;

  assign hwIdx     = addrQ[15:1];
  assign idxS      = hwIdx[IDX_W-1:0];
  assign addrBad   = (hwIdx >= 15'(TOTAL_HW));
  assign userBad   = (hwIdx >= 15'(USER_HW));
  assign curWord   = memQ[idxS];
  assign curCnt    = wcntQ[idxS];
  assign countFull = (curCnt >= 2'd2);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
    end else begin
      if (strb.ldAddr) addrQ <= wdata;
      if (strb.ldData)      dataQ <= wdata;
      else if (strb.doRead) dataQ <= curWord;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < TOTAL_HW; i++) begin
        memQ[i]  <= 16'hFFFF;
        wcntQ[i] <= 2'd0;
      end
    end else begin
      for (int i = 0; i < TOTAL_HW; i++) begin
        if (strb.doErase && ((IDX_W'(i) >> OFF_W) == (idxS >> OFF_W))) begin
          memQ[i]  <= 16'hFFFF;
          wcntQ[i] <= 2'd0;
        end else if (strb.doProg && (idxS == IDX_W'(i))) begin
          memQ[i]  <= memQ[i] & dataQ;
          wcntQ[i] <= wcntQ[i] + 2'd1;
        end
      end
    end
  end

  // R3
  prog_and_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.doProg |=> curWord == ($past(curWord) & $past(dataQ)));

  // R7
  count_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.doProg |=> curCnt == $past(curCnt) + 2'd1);

  // R7
  count_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    curCnt != 2'd3);

  // R5
  erase_ones_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.doErase |=> (curWord == 16'hFFFF) && (curCnt == 2'd0));

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import fc_pkg::*;
#(
  parameter int CYC_PER_US = 20,
  parameter int ERASE_CYC  = 409600
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busWr,
  input  logic       busRd,
  input  logic [1:0] busSel,
  input  logic [7:0] cmdCode,
  input  logic [2:0] clkDiv,
  input  logic       addrBad,
  input  logic       userBad,
  input  logic       countFull,
  output fcStrb_t    strb,
  output logic       busy,
  output logic       statDone,
  output logic       statFail
);

  localparam int PROG_MAX = 105 * CYC_PER_US;
  localparam int TMAX     = (ERASE_CYC > PROG_MAX) ? ERASE_CYC : PROG_MAX;
  localparam int CNT_W    = $clog2(TMAX + 1);

  typedef enum logic {OP_PROG, OP_ERASE} op_e;

  op_e              opQ;
  logic             busyQ;
  logic [CNT_W-1:0] cntQ;
  logic             cmdWr, finish, rdStat;
  logic             startProg, startErase, immFail, immRead;
  logic [CNT_W-1:0] progLoad;

  assign cmdWr    = busWr && (busSel == SEL_CMD) && !busyQ;
  assign finish   = busyQ && (cntQ == '0);
  assign rdStat   = busRd && (busSel == SEL_STAT) && !busyQ;
  assign progLoad = CNT_W'(progMicros(clkDiv) * CYC_PER_US - 1);

  always_comb begin
    startProg  = 1'b0;
    startErase = 1'b0;
    immFail    = 1'b0;
    immRead    = 1'b0;
    if (cmdWr) begin
      case (cmdCode)
        CMD_READ:  if (addrBad) immFail = 1'b1; else immRead = 1'b1;
        CMD_PROG:  if (userBad || countFull) immFail = 1'b1; else startProg = 1'b1;
        CMD_ERASE: if (userBad) immFail = 1'b1; else startErase = 1'b1;
        default:   immFail = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      cntQ  <= '0;
      opQ   <= OP_PROG;
    end else if (startProg) begin
      busyQ <= 1'b1;
      cntQ  <= progLoad;
      opQ   <= OP_PROG;
    end else if (startErase) begin
      busyQ <= 1'b1;
      cntQ  <= CNT_W'(ERASE_CYC - 1);
      opQ   <= OP_ERASE;
    end else if (busyQ) begin
      if (cntQ == '0) busyQ <= 1'b0;
      else            cntQ  <= cntQ - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statDone <= 1'b0;
      statFail <= 1'b0;
    end else begin
      if (finish || immRead || immFail) statDone <= 1'b1;
      else if (rdStat)                  statDone <= 1'b0;
      if (immFail)     statFail <= 1'b1;
      else if (rdStat) statFail <= 1'b0;
    end
  end

  assign busy         = busyQ;
  assign strb.ldAddr  = busWr && (busSel == SEL_ADDR) && !busyQ;
  assign strb.ldData  = busWr && (busSel == SEL_DATA) && !busyQ;
  assign strb.doRead  = immRead;
  assign strb.doProg  = finish && (opQ == OP_PROG);
  assign strb.doErase = finish && (opQ == OP_ERASE);

  // R10
  done_on_finish_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyQ) |-> statDone);

  // R8
  bad_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && (cmdCode == CMD_PROG || cmdCode == CMD_ERASE) && userBad)
      |=> (statFail && !busyQ));

  // R7
  third_prog_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && cmdCode == CMD_PROG && countFull) |=> (statFail && !busyQ));

  // R9
  bad_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && cmdCode != CMD_READ && cmdCode != CMD_PROG && cmdCode != CMD_ERASE)
      |=> (statFail && !busyQ));

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import fc_pkg::*;
#(
  parameter int PAGE_HW    = 256,
  parameter int NUM_PAGES  = 4,
  parameter int RSV_PAGES  = 1,
  parameter int CYC_PER_US = 20,
  parameter int ERASE_CYC  = 409600
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWr,
  input  logic        busRd,
  input  logic [1:0]  busSel,
  input  logic [15:0] busWdata,
  output logic [15:0] busRdata,
  output logic        busReady,
  input  logic [2:0]  clkDiv
);

  fcStrb_t     strb;
  logic        busy, statDone, statFail;
  logic        addrBad, userBad, countFull;
  logic [15:0] addrQ, dataQ;

  flash_cmd_fsm #(
    .CYC_PER_US(CYC_PER_US),
    .ERASE_CYC (ERASE_CYC)
  ) fsm_i (
    .clk      (clk),
    .rstN     (rstN),
    .busWr    (busWr),
    .busRd    (busRd),
    .busSel   (busSel),
    .cmdCode  (busWdata[7:0]),
    .clkDiv   (clkDiv),
    .addrBad  (addrBad),
    .userBad  (userBad),
    .countFull(countFull),
    .strb     (strb),
    .busy     (busy),
    .statDone (statDone),
    .statFail (statFail)
  );

  flash_cmd_dpath #(
    .PAGE_HW  (PAGE_HW),
    .NUM_PAGES(NUM_PAGES),
    .RSV_PAGES(RSV_PAGES)
  ) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wdata    (busWdata),
    .addrQ    (addrQ),
    .dataQ    (dataQ),
    .addrBad  (addrBad),
    .userBad  (userBad),
    .countFull(countFull)
  );

  assign busReady = !busy;

  always_comb begin
    case (busSel)
      SEL_ADDR: busRdata = addrQ;
      SEL_DATA: busRdata = dataQ;
      SEL_STAT: busRdata = {13'd0, statFail, statDone, busy};
      default:  busRdata = 16'd0;
    endcase
  end

endmodule

// File: tb/flash_cmd_ctrl_tb_top.sv
module flash_cmd_ctrl_tb_top;

  localparam int PAGE_HW  = 256;
  localparam int NPAGES   = 4;
  localparam int TOTAL    = PAGE_HW * NPAGES;
  localparam int USERHW   = PAGE_HW * (NPAGES - 1);
  localparam int ERASE_N  = 300;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0, busRd = 1'b0;
  logic [1:0]  busSel = 2'd0;
  logic [15:0] busWdata = 16'd0;
  logic [15:0] busRdata;
  logic        busReady;
  logic [2:0]  clkDiv = 3'd0;

  int checks = 0;
  int failures = 0;
  string curReq = "R1";

  always #2 clk = ~clk;

  flash_cmd_ctrl #(
    .PAGE_HW(PAGE_HW), .NUM_PAGES(NPAGES), .RSV_PAGES(1),
    .CYC_PER_US(1), .ERASE_CYC(ERASE_N)
  ) dut_i (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busSel(busSel),
    .busWdata(busWdata), .busRdata(busRdata), .busReady(busReady), .clkDiv(clkDiv)
  );

  // behavioural reference model
  int mMem[TOTAL];
  int mCnt[TOTAL];
  int mAddr, mData, mTimer, mOp, mBusy, mDone, mFail;

  function automatic int usOf(int d);
    if (d <= 3) return 50;
    if (d <= 5) return 70;
    if (d == 6) return 80;
    return 105;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < TOTAL; i++) begin mMem[i] = 'hFFFF; mCnt[i] = 0; end
      mAddr = 0; mData = 0; mTimer = 0; mOp = 0; mBusy = 0; mDone = 0; mFail = 0;
    end else if (mBusy != 0) begin
      mTimer--;
      if (mTimer == 0) begin
        int idx;
        idx = mAddr / 2;
        if (mOp == 2) begin
          mMem[idx] = mMem[idx] & mData;
          mCnt[idx]++;
        end else begin
          for (int i = 0; i < TOTAL; i++)
            if (i / PAGE_HW == idx / PAGE_HW) begin mMem[i] = 'hFFFF; mCnt[i] = 0; end
        end
        mBusy = 0; mDone = 1;
      end
    end else if (busWr) begin
      int idx;
      idx = mAddr / 2;
      case (busSel)
        2'd1: mAddr = busWdata;
        2'd2: mData = busWdata;
        2'd0: begin
          mDone = 1;
          if (busWdata[7:0] == 8'h01 && idx < TOTAL) mData = mMem[idx];
          else if (busWdata[7:0] == 8'h02 && idx < USERHW && mCnt[idx] < 2) begin
            mBusy = 1; mOp = 2; mTimer = usOf(int'(clkDiv)); mDone = 0;
          end else if (busWdata[7:0] == 8'h03 && idx < USERHW) begin
            mBusy = 1; mOp = 3; mTimer = ERASE_N; mDone = 0;
          end else mFail = 1;
        end
        default: ;
      endcase
    end else if (busRd && busSel == 2'd3) begin
      mDone = 0; mFail = 0;
    end
  end

  function automatic int modelRead(logic [1:0] s);
    case (s)
      2'd1: return mAddr;
      2'd2: return mData;
      2'd3: return mFail * 4 + mDone * 2 + mBusy;
      default: return 0;
    endcase
  endfunction

  // compare against the model on every clock
  always @(negedge clk) begin
    if (rstN) begin
      checks++;
      if (busReady !== (mBusy == 0)) begin
        failures++;
        $display("FAIL %s ready: actual=%0b expected=%0b", curReq, busReady, mBusy == 0);
      end
      if (busRd) begin
        checks++;
        if (int'(busRdata) != modelRead(busSel)) begin
          failures++;
          $display("FAIL %s model read sel %0d: actual=%h expected=%h",
                   curReq, busSel, busRdata, modelRead(busSel));
        end
      end
    end
  end

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wrReg(logic [1:0] s, logic [15:0] v);
    @(posedge clk); #1;
    busWr = 1'b1; busSel = s; busWdata = v;
    @(posedge clk); #1;
    busWr = 1'b0;
  endtask

  task automatic rdReg(logic [1:0] s, int exp);
    @(posedge clk); #1;
    busRd = 1'b1; busSel = s;
    @(negedge clk);
    check(curReq, int'(busRdata), exp, "register read");
    @(posedge clk); #1;
    busRd = 1'b0;
  endtask

  task automatic cmd(logic [7:0] code, logic [2:0] div, int expLow);
    int low;
    clkDiv = div;
    wrReg(2'd0, {8'd0, code});
    low = 0;
    while (busReady == 1'b0) begin
      low++;
      @(posedge clk); #1;
    end
    check(curReq, low, expLow, "stall cycles");
  endtask

  task automatic readMem(logic [15:0] a, int exp);
    wrReg(2'd1, a);
    cmd(8'h01, 3'd0, 0);
    rdReg(2'd2, exp);
  endtask

  task automatic progMem(logic [15:0] a, logic [15:0] d, logic [2:0] div, int expLow);
    wrReg(2'd1, a);
    wrReg(2'd2, d);
    cmd(8'h02, div, expLow);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog (R4 R6 stall did not end)");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;

    curReq = "R1";
    rdReg(2'd3, 0);
    readMem(16'h0000, 'hFFFF);
    readMem(16'h05FE, 'hFFFF);
    readMem(16'h07FE, 'hFFFF);

    curReq = "R10";
    rdReg(2'd3, 2);
    rdReg(2'd3, 0);

    curReq = "R2";
    wrReg(2'd1, 16'h0010);
    rdReg(2'd1, 'h0010);

    curReq = "R3";
    progMem(16'h0010, 16'h1234, 3'd0, 50);
    readMem(16'h0010, 'h1234);
    progMem(16'h0010, 16'hFF0F, 3'd5, 70);
    readMem(16'h0010, 'h1204);
    readMem(16'h0012, 'hFFFF);

    curReq = "R7";
    progMem(16'h0010, 16'h0000, 3'd7, 0);
    rdReg(2'd3, 6);
    readMem(16'h0010, 'h1204);

    curReq = "R4";
    progMem(16'h0020, 16'hA5A5, 3'd6, 80);
    progMem(16'h0022, 16'h5A5A, 3'd7, 105);
    progMem(16'h0024, 16'h00F0, 3'd3, 50);
    progMem(16'h0026, 16'h0F00, 3'd4, 70);
    readMem(16'h0020, 'hA5A5);
    readMem(16'h0022, 'h5A5A);

    curReq = "R5";
    progMem(16'h0200, 16'h0000, 3'd0, 50);
    wrReg(2'd1, 16'h0010);
    cmd(8'h03, 3'd7, ERASE_N);
    readMem(16'h0010, 'hFFFF);
    readMem(16'h0020, 'hFFFF);
    readMem(16'h01FE, 'hFFFF);
    readMem(16'h0200, 'h0000);
    progMem(16'h0010, 16'h00FF, 3'd0, 50);
    progMem(16'h0010, 16'h00FF, 3'd0, 50);
    readMem(16'h0010, 'h00FF);

    curReq = "R6";
    wrReg(2'd1, 16'h03FE);
    cmd(8'h03, 3'd0, ERASE_N);
    readMem(16'h0200, 'hFFFF);
    readMem(16'h0010, 'h00FF);

    curReq = "R8";
    rdReg(2'd3, 2);
    progMem(16'h0600, 16'h0000, 3'd0, 0);
    rdReg(2'd3, 6);
    wrReg(2'd1, 16'h07FE);
    cmd(8'h03, 3'd0, 0);
    rdReg(2'd3, 6);
    progMem(16'h0800, 16'h0000, 3'd0, 0);
    rdReg(2'd3, 6);
    wrReg(2'd1, 16'h0800);
    cmd(8'h01, 3'd0, 0);
    rdReg(2'd3, 6);
    readMem(16'h0600, 'hFFFF);

    curReq = "R9";
    rdReg(2'd3, 2);
    wrReg(2'd1, 16'h0010);
    cmd(8'h00, 3'd0, 0);
    rdReg(2'd3, 6);
    cmd(8'h7E, 3'd0, 0);
    rdReg(2'd3, 6);
    readMem(16'h0010, 'h00FF);

    curReq = "R11";
    rdReg(2'd3, 2);

    summary();
    $finish;
  end

endmodule